// File: doc/BRIEF.md
# Masked Block Write-Back Unit

This unit moves an eight-word write buffer into a small on-chip DRAM-style array as one block. A host loads words into the buffer byte by byte. Every byte loaded is marked in a per-byte transfer mask. A command then copies the buffer into one block of the row that is currently open. Only the marked bytes overwrite the array; unmarked bytes keep what the array already held. The buffer and its mask survive the transfer, so the same data can be written again to other blocks.

A second flavour of the transfer command writes the block the same way and also loads the merged result, as the array now holds it, into two read buffers. The host then reads those buffers one word at a time. A row must be opened before a transfer. The array is an internal, parameterised memory with one byte lane per byte of a block, so it maps onto block RAM.

Top module: `blkx_xfer_top`

## Requirements
- R1: After reset `busy` and `err` are 0, no row is open, and both read buffers hold zero, so `rb_data` reads 0.
- R2: A host load with `hw_en` writes each byte of word `hw_addr` whose `hw_be` bit is set (`hw_be[0]` is bits 7:0, `hw_be[1]` is bits 15:8) and sets that byte's mask bit. Mask bit 2w covers the low byte of word w, and bit 2w+1 covers its high byte. `mask_clr` clears every mask bit and leaves the data alone; a byte loaded in the same cycle is still marked.
- R3: Command `cmd_op`=2'b10 writes the buffer into block `cmd_addr[7:3]` of the open row. A byte whose mask bit is 1 takes the buffer byte; a byte whose mask bit is 0 keeps its old value. The read buffers do not change.
- R4: A transfer leaves the buffer data and the mask unchanged.
- R5: Command `cmd_op`=2'b11 performs the R3 write and loads both read buffers with the merged block. `rb_sel` picks read buffer 0 or 1, and `rb_addr` picks the word. `rb_data` shows that word one cycle later.
- R6: A transfer command with any of `cmd_addr[11:8]` set is rejected. `err` is 1 for the single cycle after that command, no busy period starts, and the array does not change.
- R7: A transfer command while no row is open is rejected the same way. `cmd_op`=2'b01 closes the open row.
- R8: `cmd_op`=2'b00 opens row `cmd_addr[11:0]`. A row number of 2^ROW_AW or more is rejected with `err`, and the row that was open before stays open.
- R9: An accepted transfer holds `busy` high for exactly XFER cycles, starting in the cycle after the command. While `busy` is high, commands, host loads and mask clears are ignored.
- R10: `cmd_addr[2:0]` has no effect on a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Load bytes into the write buffer |
| hw_addr | input | 3 | Word index for the load |
| hw_data | input | 16 | Load data |
| hw_be | input | 2 | Byte enables for the load |
| mask_clr | input | 1 | Clear the whole transfer mask |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 open row, 01 close row, 10 write, 11 write and read |
| cmd_addr | input | 12 | Row number (open) or column address (transfers) |
| rb_sel | input | 1 | Read buffer select |
| rb_addr | input | 3 | Read buffer word index |
| rb_data | output | 16 | Registered read buffer word |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | One-cycle pulse for a rejected command |

## Verification
The hard part is seeing what a write-only transfer left in the array, because the array has no direct read path. The bench gets there by opening the row, clearing the mask and issuing a write-and-read to the same block. With an empty mask that transfer writes nothing, so the read buffers show the array's current contents. This peek is used after masked writes, after rejected commands and after intrusions during a busy period. Constrained random traffic also mixes partial loads, mask clears, row changes and illegal addresses, so the mask reaches many shapes before each transfer.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [1:0] {
    OP_OPEN   = 2'b00,
    OP_CLOSE  = 2'b01,
    OP_PUT    = 2'b10,
    OP_PUTGET = 2'b11
  } blkx_op_e;
endpackage

// File: rtl/blkx_wbuf.sv
// Write buffer with per-byte transfer mask.
module blkx_wbuf #(
  parameter int WORDS = 8,
  parameter int DW    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ld_en,
  input  logic [$clog2(WORDS)-1:0]   ld_addr,
  input  logic [DW-1:0]              ld_data,
  input  logic [DW/8-1:0]            ld_be,
  input  logic                       clr,
  output logic [WORDS*DW-1:0]        blk_o,
  output logic [WORDS*DW/8-1:0]      msk_o
);
  localparam int BPW = DW / 8;

  logic [WORDS*DW-1:0]   data_q;
  logic [WORDS*BPW-1:0]  msk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      msk_q  <= '0;
    end else begin
      if (clr) msk_q <= '0;
      if (ld_en) begin
        for (int b = 0; b < BPW; b++) begin
          if (ld_be[b]) begin
            data_q[ld_addr*DW + b*8 +: 8] <= ld_data[b*8 +: 8];
            msk_q[ld_addr*BPW + b]        <= 1'b1;
          end
        end
      end
    end
  end

  assign blk_o = data_q;
  assign msk_o = msk_q;
endmodule

// File: rtl/blkx_array.sv
// Block-wide array, one byte lane per memory so block RAM can be inferred.
module blkx_array #(
  parameter int AW = 7,
  parameter int NB = 16
) (
  input  logic            clk,
  input  logic            we,
  input  logic [NB-1:0]   be,
  input  logic [AW-1:0]   addr,
  input  logic [NB*8-1:0] wdata,
  output logic [NB*8-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] rd_q;
    always_ff @(posedge clk) begin
      if (we && be[g]) lane_mem[addr] <= wdata[g*8 +: 8];
      rd_q <= lane_mem[addr];
    end
    assign rdata[g*8 +: 8] = rd_q;
  end
endmodule

// File: rtl/blkx_rbuf.sv
// One read buffer holding a full block.
module blkx_rbuf #(
  parameter int WORDS = 8,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld,
  input  logic [WORDS*DW-1:0]      blk_i,
  input  logic [$clog2(WORDS)-1:0] rd_addr,
  output logic [DW-1:0]            word_o
);
  logic [WORDS*DW-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (rst)     buf_q <= '0;
    else if (ld) buf_q <= blk_i;
  end

  assign word_o = buf_q[rd_addr*DW +: DW];
endmodule

// File: rtl/blkx_ctrl.sv
// Command decode, row state and transfer sequencing.
module blkx_ctrl
  import blkx_pkg::*;
#(
  parameter int CMD_AW = 12,
  parameter int ROW_AW = 2,
  parameter int BLK_AW = 5,
  parameter int WAW    = 3,
  parameter int XFER   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  blkx_op_e                 cmd_op,
  input  logic [CMD_AW-1:0]        cmd_addr,
  output logic                     busy,
  output logic                     err,
  output logic                     mem_we,
  output logic                     rb_ld,
  output logic [ROW_AW+BLK_AW-1:0] mem_addr
);
  localparam int PHW    = (XFER > 2) ? $clog2(XFER) : 1;
  localparam int HI_LSB = WAW + BLK_AW;

  logic              row_open_q;
  logic [ROW_AW-1:0] row_q;
  logic [BLK_AW-1:0] blk_q;
  logic              rd_mode_q;
  logic [PHW-1:0]    ph_q;
  logic              busy_q, err_q;

  logic row_ok, col_ok;
  assign row_ok = (cmd_addr[CMD_AW-1:ROW_AW] == '0);
  assign col_ok = (cmd_addr[CMD_AW-1:HI_LSB] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_open_q <= 1'b0;
      row_q      <= '0;
      blk_q      <= '0;
      rd_mode_q  <= 1'b0;
      ph_q       <= '0;
      busy_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (busy_q) begin
        if (ph_q == PHW'(XFER - 1)) begin
          busy_q <= 1'b0;
          ph_q   <= '0;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end else if (cmd_valid) begin
        unique case (cmd_op)
          OP_OPEN: begin
            if (row_ok) begin
              row_open_q <= 1'b1;
              row_q      <= cmd_addr[ROW_AW-1:0];
            end else begin
              err_q <= 1'b1;
            end
          end
          OP_CLOSE: row_open_q <= 1'b0;
          default: begin
            if (!row_open_q || !col_ok) begin
              err_q <= 1'b1;
            end else begin
              busy_q    <= 1'b1;
              ph_q      <= '0;
              rd_mode_q <= (cmd_op == OP_PUTGET);
              blk_q     <= cmd_addr[HI_LSB-1:WAW];
            end
          end
        endcase
      end
    end
  end

  // Phase 0 writes the array; phase 1 captures the merged block.
  assign mem_we   = busy_q && (ph_q == '0);
  assign rb_ld    = busy_q && (ph_q == PHW'(1)) && rd_mode_q;
  assign mem_addr = {row_q, blk_q};
  assign busy     = busy_q;
  assign err      = err_q;
endmodule

// File: rtl/blkx_xfer_top.sv
module blkx_xfer_top
  import blkx_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DW     = 16,
  parameter int CMD_AW = 12,
  parameter int ROW_AW = 2,
  parameter int BLK_AW = 5,
  parameter int XFER   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hw_en,
  input  logic [$clog2(WORDS)-1:0] hw_addr,
  input  logic [DW-1:0]            hw_data,
  input  logic [DW/8-1:0]          hw_be,
  input  logic                     mask_clr,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [CMD_AW-1:0]        cmd_addr,
  input  logic                     rb_sel,
  input  logic [$clog2(WORDS)-1:0] rb_addr,
  output logic [DW-1:0]            rb_data,
  output logic                     busy,
  output logic                     err
);
  localparam int WAW  = $clog2(WORDS);
  localparam int NB   = WORDS * DW / 8;
  localparam int BLKW = WORDS * DW;
  localparam int MAW  = ROW_AW + BLK_AW;
  localparam int NRB  = 2;

  logic [BLKW-1:0] wb_blk, mem_rd, merged;
  logic [NB-1:0]   wb_msk;
  logic            mem_we, rb_ld;
  logic [MAW-1:0]  mem_addr;
  logic [DW-1:0]   rb_word [NRB];

  blkx_ctrl #(
    .CMD_AW(CMD_AW), .ROW_AW(ROW_AW), .BLK_AW(BLK_AW), .WAW(WAW), .XFER(XFER)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(blkx_op_e'(cmd_op)),
    .cmd_addr(cmd_addr), .busy(busy), .err(err), .mem_we(mem_we),
    .rb_ld(rb_ld), .mem_addr(mem_addr)
  );

  blkx_wbuf #(.WORDS(WORDS), .DW(DW)) u_wbuf (
    .clk(clk), .rst(rst), .ld_en(hw_en && !busy), .ld_addr(hw_addr),
    .ld_data(hw_data), .ld_be(hw_be), .clr(mask_clr && !busy),
    .blk_o(wb_blk), .msk_o(wb_msk)
  );

  blkx_array #(.AW(MAW), .NB(NB)) u_array (
    .clk(clk), .we(mem_we), .be(wb_msk), .addr(mem_addr),
    .wdata(wb_blk), .rdata(mem_rd)
  );

  // mem_rd holds the pre-write contents (read-first) in phase 1.
  always_comb begin
    for (int i = 0; i < NB; i++)
      merged[i*8 +: 8] = wb_msk[i] ? wb_blk[i*8 +: 8] : mem_rd[i*8 +: 8];
  end

  for (genvar r = 0; r < NRB; r++) begin : g_rb
    blkx_rbuf #(.WORDS(WORDS), .DW(DW)) u_rbuf (
      .clk(clk), .rst(rst), .ld(rb_ld), .blk_i(merged),
      .rd_addr(rb_addr), .word_o(rb_word[r])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rb_data <= '0;
    else     rb_data <= rb_word[rb_sel];
  end
endmodule

// File: rtl/blkx_xfer_chk.sv
module blkx_xfer_chk #(
  parameter int XFER = 2,
  parameter int NB   = 16,
  parameter int BLKW = 128
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic            busy,
  input logic            err,
  input logic            mem_we,
  input logic            rb_ld,
  input logic [NB-1:0]   wb_msk,
  input logic [BLKW-1:0] wb_blk
);
  int unsigned run_cnt;
  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  assert_busy_len_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_cnt < XFER));
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid));
  assert_err_src_R6: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(cmd_valid && !busy));
  assert_err_nobusy_R7: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);
  assert_buf_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> ($stable(wb_msk) && $stable(wb_blk)));
  assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  assert_rbld_after_we_R5: assert property (@(posedge clk) disable iff (rst)
    rb_ld |-> $past(mem_we));
endmodule

bind blkx_xfer_top blkx_xfer_chk #(.XFER(XFER), .NB(NB), .BLKW(BLKW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy), .err(err),
  .mem_we(mem_we), .rb_ld(rb_ld), .wb_msk(wb_msk), .wb_blk(wb_blk)
);

// File: tb/tb_blkx_xfer_top.sv
module tb_blkx_xfer_top;
  localparam int XFER = 2;
  localparam int NROW = 4;
  localparam int NBLK = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hw_en = 0, mask_clr = 0, cmd_valid = 0, rb_sel = 0;
  logic [2:0]  hw_addr = 0, rb_addr = 0;
  logic [15:0] hw_data = 0;
  logic [1:0]  hw_be = 0, cmd_op = 0;
  logic [11:0] cmd_addr = 0;
  logic [15:0] rb_data;
  logic        busy, err;

  always #5 clk = ~clk;

  blkx_xfer_top dut (
    .clk(clk), .rst(rst), .hw_en(hw_en), .hw_addr(hw_addr), .hw_data(hw_data),
    .hw_be(hw_be), .mask_clr(mask_clr), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .rb_sel(rb_sel), .rb_addr(rb_addr), .rb_data(rb_data),
    .busy(busy), .err(err)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  logic [127:0] mdl [NROW][NBLK];
  logic [127:0] m_wb = '0, m_rb = '0;
  logic [15:0]  m_msk = '0;
  int           m_row = 0;
  bit           m_open = 0;

  function automatic logic [127:0] merge(logic [127:0] old, logic [127:0] d, logic [15:0] m);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[i*8 +: 8] = m[i] ? d[i*8 +: 8] : old[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
    hw_en = 1; hw_addr = a; hw_data = d; hw_be = be;
    @(negedge clk);
    hw_en = 0;
    for (int b = 0; b < 2; b++)
      if (be[b]) begin
        m_wb[a*16 + b*8 +: 8] = d[b*8 +: 8];
        m_msk[a*2 + b] = 1'b1;
      end
  endtask

  task automatic clr();
    mask_clr = 1;
    @(negedge clk);
    mask_clr = 0;
    m_msk = '0;
  endtask

  task automatic check_rb(input string tag);
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 8; w++) begin
        rb_sel = s[0]; rb_addr = w[2:0];
        @(negedge clk);
        chk(rb_data === m_rb[w*16 +: 16], tag, rb_data, m_rb[w*16 +: 16]);
      end
  endtask

  // Issue one command; optionally poke inputs during the first busy cycle.
  task automatic cmd(input logic [1:0] op, input logic [11:0] a, input bit intrude, input string tag);
    bit exp_err, go;
    int blk;
    exp_err = 0; go = 0; blk = a[7:3];
    case (op)
      2'b00: exp_err = (a[11:2] != 0);
      2'b01: exp_err = 0;
      default: begin exp_err = !m_open || (a[11:8] != 0); go = !exp_err; end
    endcase
    cmd_valid = 1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0;
    chk(err === exp_err, tag, err, exp_err);
    if (op == 2'b00 && !exp_err) begin m_open = 1; m_row = a[1:0]; end
    if (op == 2'b01) m_open = 0;
    if (go) begin
      for (int k = 0; k < XFER; k++) begin
        chk(busy === 1'b1, "R9 busy during transfer", busy, 1);
        if (k == 0 && intrude) begin
          cmd_valid = 1; cmd_op = 2'b10; cmd_addr = 12'h0F8;
          hw_en = 1; hw_addr = 3'd0; hw_data = 16'hDEAD; hw_be = 2'b11; mask_clr = 1;
        end
        @(negedge clk);
        cmd_valid = 0; hw_en = 0; mask_clr = 0;
        if (k > 0 || intrude) chk(err === 1'b0, "R9 no err while busy", err, 0);
      end
      mdl[m_row][blk] = merge(mdl[m_row][blk], m_wb, m_msk);
      if (op == 2'b11) m_rb = mdl[m_row][blk];
    end
    chk(busy === 1'b0, "R9 busy released", busy, 0);
  endtask

  // Observe array contents: empty mask, write-and-read.
  task automatic peek(input int row, input int blk, input string tag);
    cmd(2'b00, row[11:0], 0, "R8 open for peek");
    clr();
    cmd(2'b11, 12'(blk << 3), 0, tag);
    check_rb(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    chk(err === 1'b0, "R1 err after reset", err, 0);
    check_rb("R1 read buffers zero");
    cmd(2'b10, 12'h000, 0, "R1 R7 transfer with no open row");

    // Fill every block with known data.
    for (int r = 0; r < NROW; r++) begin
      cmd(2'b00, r[11:0], 0, "R8 open row");
      for (int b = 0; b < NBLK; b++) begin
        for (int w = 0; w < 8; w++) load(w[2:0], 16'($urandom), 2'b11);
        cmd(2'b10, 12'(b << 3), 0, "R3 init write");
      end
    end

    // Masked write with junk in the low address bits.
    cmd(2'b00, 12'd1, 0, "R8 open row 1");
    clr();
    load(3'd2, 16'hA55A, 2'b01);
    load(3'd5, 16'h1234, 2'b11);
    load(3'd7, 16'hBEEF, 2'b10);
    cmd(2'b10, 12'((7 << 3) | 5), 0, "R10 low bits ignored");
    check_rb("R3 read buffers untouched by write");
    peek(1, 7, "R3 R2 masked merge");

    // Same buffer reused for two blocks.
    cmd(2'b00, 12'd2, 0, "R8 open row 2");
    for (int w = 0; w < 8; w++) load(w[2:0], 16'($urandom), (w % 3 == 0) ? 2'b01 : 2'b11);
    cmd(2'b10, 12'(3 << 3), 0, "R4 first write");
    cmd(2'b11, 12'(4 << 3), 0, "R4 second write reuses buffer");
    check_rb("R5 R4 merged block in read buffers");
    peek(2, 3, "R4 first block");

    // Illegal column bits.
    load(3'd1, 16'hFFFF, 2'b11);
    cmd(2'b10, 12'h200 | 12'(9 << 3), 0, "R6 high column bits");
    peek(2, 9, "R6 array unchanged");

    // Closed row.
    cmd(2'b01, 12'd0, 0, "R7 close");
    load(3'd0, 16'h0F0F, 2'b11);
    cmd(2'b11, 12'(6 << 3), 0, "R7 transfer after close");

    // Out-of-range row keeps row 3 open.
    cmd(2'b00, 12'd3, 0, "R8 open row 3");
    cmd(2'b00, 12'h004, 0, "R8 row out of range");
    load(3'd4, 16'h5AA5, 2'b11);
    cmd(2'b11, 12'(11 << 3), 0, "R8 previous row still open");
    check_rb("R8 readback on kept row");

    // Intrusion while busy.
    load(3'd3, 16'hC3C3, 2'b11);
    cmd(2'b10, 12'(12 << 3), 1, "R9 accept with intrusion");
    peek(3, 31, "R9 intruding command ignored");
    load(3'd6, 16'h7777, 2'b01);
    cmd(2'b11, 12'(13 << 3), 0, "R9 buffer after intrusion");
    check_rb("R9 intruding load ignored");

    // Random traffic.
    for (int it = 0; it < 400; it++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r <= 3) load(3'($urandom), 16'($urandom), 2'($urandom));
      else if (r == 4) clr();
      else if (r == 5 || (r == 6 && $urandom_range(0, 2) != 0))
        cmd(2'b00, ($urandom_range(0, 5) == 0) ? 12'h010 : 12'($urandom_range(0, 3)), 0, "R8 random open");
      else if (r == 6) cmd(2'b01, 12'd0, 0, "R7 random close");
      else begin
        logic [11:0] a;
        a = {4'h0, 8'($urandom)};
        if ($urandom_range(0, 7) == 0) a[11:8] = 4'($urandom_range(1, 15));
        cmd(r == 7 ? 2'b10 : 2'b11, a, 0, "R6 R7 random transfer");
        if (r != 7) check_rb("R5 random readback");
      end
    end

    // Final sweep of row 0.
    for (int b = 0; b < NBLK; b += 5) peek(0, b, "R3 final sweep");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule